// File: doc/BRIEF.md
# CAM Match-Logic Self-Test Sequencer

This block tests the compare path of a content-addressable memory (32 entries of 32 bits by default). It drives the CAM's write port and compare port and then judges the vector of per-entry hit lines that comes back. Every entry is compared against the compare word at the same time. An entry hits when every bit of the XOR of the inverted compare word with the stored word is 1, which is the same as the two words being equal. The goal is to show that, for every entry and every bit position, the compare logic can produce both a hit and a miss with that bit stored as a 1 and as a 0. The storage cells themselves are left to ordinary memory self-test.

A pulse on `start_i` launches the run. The sequencer first loads an alternating background (0xAAAAAAAA at the default width) into all entries. It then takes the entries one at a time. For the entry under test it writes zero and checks for a hit with a zero compare word. It then walks a single set bit from bit 0 up to the top bit. For each bit it checks a miss, writes the one-hot word, checks a hit on it and checks a miss against zero. Finally it restores the background in that entry.

On each check, the hit line of the entry under test must match the expected value. Every other entry must miss unless the compare word equals the background. The first mismatch stops the run and latches the entry, the bit and the expected hit value. The CAM is assumed to return its hit vector one cycle after a compare is issued.

Top module: `cam_match_bist`

## Requirements
- R1: After reset, `done_o`, `fail_o`, `busy_o`, `cam_we_o` and `cam_cmp_valid_o` are all 0.
- R2: Once `start_i` has been sampled in idle, done or fail, the next 32 cycles write the background word 0xAAAAAAAA to addresses 0, 1, …, 31 in that order, one write per cycle, with no compare.
- R3: For each entry e, the operations run in this order: write 0 to e, then compare 0 (expect hit). Then, for bit b from 0 to 31: compare 1<<b (expect miss), write 1<<b to e, compare 1<<b (expect hit), compare 0 (expect miss).
- R4: A compare is held for one cycle. The cycle after it carries neither a write nor a compare, and the hit vector is judged in that cycle.
- R5: After bit 31 of entry e, the next operation is a write of 0xAAAAAAAA to e. The cycle after that is the zero write to entry e+1.
- R6: With a healthy CAM, `done_o` first reads 1 after the 7328th rising edge following the edge that samples `start_i`, and `busy_o` falls at the same time.
- R7: On the first check where a hit line differs from its expected value, `fail_o` rises and stays high. No further write or compare is issued.
- R8: `fail_entry_o` and `fail_bit_o` hold the entry under test and the walking-bit index of the failing check. `fail_exp_o` holds the expected hit value of the entry under test. Before the walk starts, the bit index reads 0.
- R9: A hit from any entry other than the one under test, when the compare word differs from the background, counts as a failure and is reported against the entry under test.
- R10: `done_o` and `fail_o` are never 1 together. A `start_i` sampled in the done or fail state clears both and restarts the run.
- R11: `start_i` has no effect while the run is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test run (ignored while busy) |
| cam_hit_i | input | 32 | Per-entry hit vector from the CAM, one cycle after a compare |
| cam_we_o | output | 1 | CAM write enable |
| cam_waddr_o | output | 5 | CAM write address |
| cam_wdata_o | output | 32 | CAM write data |
| cam_cmp_valid_o | output | 1 | Compare issue strobe |
| cam_cmp_data_o | output | 32 | Compare word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished without a mismatch |
| fail_o | output | 1 | Run stopped on a mismatch |
| fail_entry_o | output | 5 | Entry under test at the failing check |
| fail_bit_o | output | 5 | Walking-bit index at the failing check |
| fail_exp_o | output | 1 | Expected hit of the entry under test at the failing check |

## Verification
Two functions can fire in the same check cycle: the judgement of the entry under test and the bystander judgement of all other entries. Both feed the same stop-and-latch path. A CAM model in the bench with injectable stored-bit and hit-line faults provokes each one. For a bystander fault, the report must name the entry under test rather than the faulty entry. A second pair is the final restore and the end of the run. A stuck bit on the last entry's last bit must give `fail_o` with `done_o` still low, and the latched indices must be 31 and 31.

// File: rtl/cam_bist_pkg.sv
package cam_bist_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_WZERO,
    ST_CZERO_HIT,
    ST_CBIT_MISS,
    ST_WBIT,
    ST_CBIT_HIT,
    ST_CZERO_MISS,
    ST_RESTORE,
    ST_DONE,
    ST_FAIL
  } step_e;
endpackage

// File: rtl/cam_bist_seq.sv
module cam_bist_seq
  import cam_bist_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  localparam int EW = $clog2(ENTRIES),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mismatch_i,
  input  logic          exp_hit_i,
  output step_e         step_o,
  output logic          phase_o,
  output logic [EW-1:0] entry_o,
  output logic [BW-1:0] bit_o,
  output logic [EW-1:0] fail_entry_o,
  output logic [BW-1:0] fail_bit_o,
  output logic          fail_exp_o
);
  localparam logic [EW-1:0] LAST_E = EW'(ENTRIES - 1);
  localparam logic [BW-1:0] LAST_B = BW'(WIDTH - 1);

  step_e         step_q;
  logic          phase_q;
  logic [EW-1:0] entry_q;
  logic [BW-1:0] bit_q;
  logic [EW-1:0] fent_q;
  logic [BW-1:0] fbit_q;
  logic          fexp_q;
  logic          is_cmp;

  assign is_cmp = (step_q == ST_CZERO_HIT) || (step_q == ST_CBIT_MISS) ||
                  (step_q == ST_CBIT_HIT)  || (step_q == ST_CZERO_MISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      phase_q <= 1'b0;
      entry_q <= '0;
      bit_q   <= '0;
      fent_q  <= '0;
      fbit_q  <= '0;
      fexp_q  <= 1'b0;
    end else begin
      case (step_q)
        ST_IDLE, ST_DONE, ST_FAIL: if (start_i) begin
          step_q  <= ST_FILL;
          phase_q <= 1'b0;
          entry_q <= '0;
          bit_q   <= '0;
          fent_q  <= '0;
          fbit_q  <= '0;
          fexp_q  <= 1'b0;
        end
        ST_FILL: begin
          entry_q <= (entry_q == LAST_E) ? '0 : entry_q + 1'b1;
          if (entry_q == LAST_E) step_q <= ST_WZERO;
        end
        ST_WZERO: begin
          bit_q  <= '0;
          step_q <= ST_CZERO_HIT;
        end
        ST_WBIT: step_q <= ST_CBIT_HIT;
        ST_RESTORE: begin
          if (entry_q == LAST_E) step_q <= ST_DONE;
          else begin
            entry_q <= entry_q + 1'b1;
            step_q  <= ST_WZERO;
          end
        end
        default: if (is_cmp) begin
          if (!phase_q) phase_q <= 1'b1;
          else begin
            phase_q <= 1'b0;
            if (mismatch_i) begin
              step_q <= ST_FAIL;
              fent_q <= entry_q;
              fbit_q <= bit_q;
              fexp_q <= exp_hit_i;
            end else begin
              case (step_q)
                ST_CZERO_HIT: step_q <= ST_CBIT_MISS;
                ST_CBIT_MISS: step_q <= ST_WBIT;
                ST_CBIT_HIT:  step_q <= ST_CZERO_MISS;
                default: begin
                  if (bit_q == LAST_B) step_q <= ST_RESTORE;
                  else begin
                    bit_q  <= bit_q + 1'b1;
                    step_q <= ST_CBIT_MISS;
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign step_o       = step_q;
  assign phase_o      = phase_q;
  assign entry_o      = entry_q;
  assign bit_o        = bit_q;
  assign fail_entry_o = fent_q;
  assign fail_bit_o   = fbit_q;
  assign fail_exp_o   = fexp_q;

  assert_fail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_FAIL && !start_i) |=> (step_q == ST_FAIL && $stable(fent_q) && $stable(fbit_q)));

  assert_fill_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_FILL && $past(step_q) == ST_FILL) |-> (entry_q == EW'($past(entry_q) + 1'b1)));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && step_q != ST_IDLE && step_q != ST_DONE && step_q != ST_FAIL && step_q != ST_FILL)
    |=> (step_q != ST_FILL));
endmodule

// File: rtl/cam_bist_pat.sv
module cam_bist_pat
  import cam_bist_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  localparam int EW = $clog2(ENTRIES),
  localparam int BW = $clog2(WIDTH)
) (
  input  step_e            step_i,
  input  logic             phase_i,
  input  logic [EW-1:0]    entry_i,
  input  logic [BW-1:0]    bit_i,
  output logic             we_o,
  output logic [EW-1:0]    waddr_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             cmp_valid_o,
  output logic [WIDTH-1:0] cmp_data_o,
  output logic             chk_o,
  output logic             exp_hit_o,
  output logic             exp_other_o
);
  function automatic logic [WIDTH-1:0] bg_word();
    logic [WIDTH-1:0] w;
    for (int i = 0; i < WIDTH; i++) w[i] = (i % 2) == 1;
    return w;
  endfunction
  localparam logic [WIDTH-1:0] BG = bg_word();

  logic [WIDTH-1:0] onehot;
  logic             cmp_st;
  assign onehot = {{(WIDTH-1){1'b0}}, 1'b1} << bit_i;

  always_comb begin
    we_o       = 1'b0;
    waddr_o    = entry_i;
    wdata_o    = '0;
    cmp_data_o = '0;
    cmp_st     = 1'b0;
    exp_hit_o  = 1'b0;
    case (step_i)
      ST_FILL, ST_RESTORE: begin we_o = 1'b1; wdata_o = BG; end
      ST_WZERO:            we_o = 1'b1;
      ST_WBIT:             begin we_o = 1'b1; wdata_o = onehot; end
      ST_CZERO_HIT:        begin cmp_st = 1'b1; exp_hit_o = 1'b1; end
      ST_CBIT_MISS:        begin cmp_st = 1'b1; cmp_data_o = onehot; end
      ST_CBIT_HIT:         begin cmp_st = 1'b1; cmp_data_o = onehot; exp_hit_o = 1'b1; end
      ST_CZERO_MISS:       cmp_st = 1'b1;
      default: ;
    endcase
  end

  assign cmp_valid_o = cmp_st && !phase_i;
  assign chk_o       = cmp_st && phase_i;
  assign exp_other_o = (cmp_data_o == BG);
endmodule

// File: rtl/cam_bist_cmp.sv
module cam_bist_cmp #(
  parameter int ENTRIES = 32,
  localparam int EW = $clog2(ENTRIES)
) (
  input  logic               chk_i,
  input  logic [EW-1:0]      entry_i,
  input  logic               exp_hit_i,
  input  logic               exp_other_i,
  input  logic [ENTRIES-1:0] hit_i,
  output logic               mismatch_o
);
  logic [ENTRIES-1:0] err;

  for (genvar j = 0; j < ENTRIES; j++) begin : g_line
    assign err[j] = hit_i[j] ^ ((entry_i == EW'(j)) ? exp_hit_i : exp_other_i);
  end

  assign mismatch_o = chk_i && (|err);
endmodule

// File: rtl/cam_match_bist.sv
module cam_match_bist
  import cam_bist_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  localparam int EW = $clog2(ENTRIES),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ENTRIES-1:0] cam_hit_i,
  output logic               cam_we_o,
  output logic [EW-1:0]      cam_waddr_o,
  output logic [WIDTH-1:0]   cam_wdata_o,
  output logic               cam_cmp_valid_o,
  output logic [WIDTH-1:0]   cam_cmp_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [EW-1:0]      fail_entry_o,
  output logic [BW-1:0]      fail_bit_o,
  output logic               fail_exp_o
);
  step_e         step;
  logic          phase;
  logic [EW-1:0] entry;
  logic [BW-1:0] bit_idx;
  logic          chk, exp_hit, exp_other, mismatch;

  cam_bist_seq #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .mismatch_i(mismatch), .exp_hit_i(exp_hit),
    .step_o(step), .phase_o(phase), .entry_o(entry), .bit_o(bit_idx),
    .fail_entry_o, .fail_bit_o, .fail_exp_o
  );

  cam_bist_pat #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_pat (
    .step_i(step), .phase_i(phase), .entry_i(entry), .bit_i(bit_idx),
    .we_o(cam_we_o), .waddr_o(cam_waddr_o), .wdata_o(cam_wdata_o),
    .cmp_valid_o(cam_cmp_valid_o), .cmp_data_o(cam_cmp_data_o),
    .chk_o(chk), .exp_hit_o(exp_hit), .exp_other_o(exp_other)
  );

  cam_bist_cmp #(.ENTRIES(ENTRIES)) u_cmp (
    .chk_i(chk), .entry_i(entry), .exp_hit_i(exp_hit), .exp_other_i(exp_other),
    .hit_i(cam_hit_i), .mismatch_o(mismatch)
  );

  assign done_o = (step == ST_DONE);
  assign fail_o = (step == ST_FAIL);
  assign busy_o = !(step == ST_IDLE || step == ST_DONE || step == ST_FAIL);

  assert_cmp_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cam_cmp_valid_o |=> (!cam_cmp_valid_o && !cam_we_o));

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_fail_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!cam_we_o && !cam_cmp_valid_o));

  assert_mismatch_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch |=> fail_o);

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cam_we_o && cam_cmp_valid_o));
endmodule

// File: tb/cam_match_bist_test.sv
module cam_match_bist_test;
  localparam int N = 32;
  localparam logic [31:0] BG = 32'hAAAA_AAAA;

  typedef struct packed {
    logic [2:0] kind;   // 0 none, 1 stored stuck-0, 2 stored stuck-1, 3 hit stuck-1, 4 hit stuck-0
    logic [4:0] ent;
    logic [4:0] bt;
    logic       ef;
    logic [4:0] ee;
    logic [4:0] eb;
    logic       ex;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 5'd0,  5'd0,  1'b0, 5'd0,  5'd0,  1'b0},
    '{3'd1, 5'd7,  5'd12, 1'b1, 5'd7,  5'd12, 1'b1},
    '{3'd2, 5'd9,  5'd20, 1'b1, 5'd9,  5'd0,  1'b1},
    '{3'd3, 5'd5,  5'd0,  1'b1, 5'd0,  5'd0,  1'b1},
    '{3'd3, 5'd0,  5'd0,  1'b1, 5'd0,  5'd0,  1'b0},
    '{3'd4, 5'd3,  5'd0,  1'b1, 5'd3,  5'd0,  1'b1},
    '{3'd1, 5'd0,  5'd0,  1'b1, 5'd0,  5'd0,  1'b1},
    '{3'd2, 5'd31, 5'd31, 1'b1, 5'd31, 5'd0,  1'b1},
    '{3'd1, 5'd31, 5'd31, 1'b1, 5'd31, 5'd31, 1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] hit;
  logic we, cv, busy, done, fail, fexp;
  logic [4:0] waddr, fent, fbit;
  logic [31:0] wdata, cdata;

  logic [2:0] f_kind = 0;
  logic [4:0] f_ent = 0, f_bit = 0;
  logic [31:0] mem [N];
  logic [N-1:0] hit_q;

  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  cam_match_bist uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cam_hit_i(hit),
    .cam_we_o(we), .cam_waddr_o(waddr), .cam_wdata_o(wdata),
    .cam_cmp_valid_o(cv), .cam_cmp_data_o(cdata),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_entry_o(fent), .fail_bit_o(fbit), .fail_exp_o(fexp)
  );

  // behavioural CAM with one-cycle compare latency and injectable faults
  always_ff @(posedge clk) begin
    if (we) begin
      logic [31:0] d;
      d = wdata;
      if (waddr == f_ent && f_kind == 3'd1) d[f_bit] = 1'b0;
      if (waddr == f_ent && f_kind == 3'd2) d[f_bit] = 1'b1;
      mem[waddr] <= d;
    end
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else if (cv) for (int j = 0; j < N; j++) hit_q[j] <= &(~cdata ^ mem[j]);
  end
  always_comb begin
    hit = hit_q;
    if (f_kind == 3'd3) hit[f_ent] = 1'b1;
    if (f_kind == 3'd4) hit[f_ent] = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_op(input string req, input bit we_e, input bit cv_e, input logic [4:0] a_e,
                        input logic [31:0] d_e);
    logic [31:0] d_a;
    d_a = we ? wdata : cdata;
    chk(we == we_e && cv == cv_e && (!we_e || waddr == a_e) && ((!we_e && !cv_e) || d_a == d_e),
        req, {we, cv, 3'b0, waddr, d_a}, {we_e, cv_e, 3'b0, a_e, d_e});
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done && !fail && !busy && !we && !cv, "R1", {done, fail, busy, we, cv}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !fail && !busy && !we && !cv, "R1", {done, fail, busy, we, cv}, 0);

    // directed full run
    start = 1;
    for (int i = 1; i <= 7329; i++) begin
      @(negedge clk);
      if (i == 1) start = 0;
      if (i == 100) start = 1;
      if (i == 101) start = 0;
      if (i <= 32) chk_op("R2 fill", 1, 0, 5'(i - 1), BG);
      case (i)
        33: chk_op("R3 zero write", 1, 0, 0, 0);
        34: chk_op("R3 cmp zero", 0, 1, 0, 0);
        35: chk_op("R4 gap", 0, 0, 0, 0);
        36: chk_op("R3 cmp bit0 miss", 0, 1, 0, 1);
        37: chk_op("R4 gap", 0, 0, 0, 0);
        38: chk_op("R3 write bit0", 1, 0, 0, 1);
        39: chk_op("R3 cmp bit0 hit", 0, 1, 0, 1);
        40: chk_op("R4 gap", 0, 0, 0, 0);
        41: chk_op("R3 cmp zero miss", 0, 1, 0, 0);
        42: chk_op("R4 gap", 0, 0, 0, 0);
        43: chk_op("R3 cmp bit1", 0, 1, 0, 2);
        102: chk(busy && !done, "R11 start ignored", {busy, done}, 2'b10);
        260: chk_op("R5 restore", 1, 0, 0, BG);
        261: chk_op("R5 next entry", 1, 0, 1, 0);
        7328: chk(!done && busy, "R6 not yet done", {done, busy}, 2'b01);
        7329: chk(done && !busy && !fail, "R6 done", {done, busy, fail}, 3'b100);
        default: ;
      endcase
    end

    // fault table
    for (int v = 0; v < NV; v++) begin
      int n;
      f_kind = VECS[v].kind; f_ent = VECS[v].ent; f_bit = VECS[v].bt;
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy && !done && !fail, "R10 restart", {busy, done, fail}, 3'b100);
      n = 0;
      while (!done && !fail && n < 8000) begin @(negedge clk); n++; end
      chk(fail == VECS[v].ef && done == !VECS[v].ef, VECS[v].kind >= 3 ? "R9 result" : "R7 result",
          {fail, done}, {VECS[v].ef, !VECS[v].ef});
      if (VECS[v].ef) begin
        chk(fent == VECS[v].ee && fbit == VECS[v].eb && fexp == VECS[v].ex, "R8 capture",
            {fent, fbit, fexp}, {VECS[v].ee, VECS[v].eb, VECS[v].ex});
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(fail && !done && !we && !cv, "R7 halt", {fail, done, we, cv}, 4'b1000);
        end
      end
    end

    // restart after fail
    f_kind = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!fail && !done && busy, "R10 clear fail", {fail, done, busy}, 3'b001);
    begin
      int n = 0;
      while (!done && !fail && n < 8000) begin @(negedge clk); n++; end
    end
    chk(done && !fail, "R10 rerun done", {done, fail}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule